// File: doc/BRIEF.md
# DMA Address Generator with Wrap

This block produces the source and destination word addresses for a single DMA channel. Each side keeps a beginning address and an active address, plus three signed step sizes. A word step is added after each word inside a burst. A burst step is added after the last word of a burst. A wrap step is applied when that side's wrap counter runs out. Source and destination each have their own wrap counter, so their address patterns can repeat with different periods. A controller outside this block decides when words and bursts end. It signals each finished word with a pulse and marks the last word of a burst with a flag. This block only does the address arithmetic.

Configuration goes through one write port into shadow registers. A transfer-start pulse copies every shadow register into the working registers at once. Software can therefore prepare the next transfer while the current one is still running, without disturbing the addresses in use.

On a wrap, the beginning address is first moved by the wrap step. The active address then restarts from the new beginning address, and the burst step is skipped for that burst. All addresses and steps count 16-bit words. Step arithmetic sign-extends the step to the full address width and wraps modulo 2^32.

Top module: `dma_addr_gen`

## Requirements
- R1: While `rst` is high, and after it falls, both addresses and both wrap counters read 0.
- R2: A configuration write (`cfg_we`=1, `cfg_side` 0 = source, 1 = destination) changes only shadow registers. The address and counter outputs do not change until the next transfer start. Field codes 6 and 7 write nothing.
- R3: A `xfer_start` pulse copies the shadow registers into the working registers. The cycle after it, each address output shows that side's current-address shadow, and each counter shows that side's wrap-size code.
- R4: `word_done`=1 with `word_last`=0 adds the word step (field code 2, 13-bit signed) to each address. Both wrap counters stay unchanged.
- R5: `word_done`=1 with `word_last`=1, on a side whose counter is not zero, adds the burst step (field code 3) to the address and decrements the counter by one.
- R6: `word_done`=1 with `word_last`=1, on a side whose counter is zero, is a wrap. The beginning address gains the wrap step (field code 5), the active address becomes the new beginning address, the burst step is not applied, and the counter reloads the wrap-size code. A code of N-1 (field code 4, 16 bits) means a wrap every N bursts, for N from 1 to 65536.
- R7: The source and destination wrap counters run independently. A wrap on one side leaves the other side's burst-step behaviour unchanged.
- R8: With neither `word_done` nor `xfer_start` high, the addresses and counters hold.
- R9: When `xfer_start` and `word_done` are high in the same cycle, the transfer start wins and no step is applied.
- R10: Steps are sign-extended to 32 bits and address arithmetic wraps modulo 2^32. For example, 1 plus two steps of -1 gives 0xFFFFFFFF.
- R11: Field code 0 writes a start address into both the beginning-address shadow and the current-address shadow. Field code 1 writes only the current-address shadow, so after a transfer start a wrap restarts from the beginning address written with code 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_side | input | 1 | 0 = source, 1 = destination |
| cfg_field | input | 3 | Field code: 0 start, 1 current only, 2 word step, 3 burst step, 4 wrap size code, 5 wrap step |
| cfg_data | input | 32 | Write data; step fields use the low 13 bits and the size field uses the low 16 bits |
| xfer_start | input | 1 | Load shadow configuration into working registers |
| word_done | input | 1 | One word has been moved; advance the addresses |
| word_last | input | 1 | Qualifies `word_done`: this word ends a burst |
| src_addr | output | 32 | Current source word address |
| dst_addr | output | 32 | Current destination word address |
| src_wcnt | output | 16 | Source bursts remaining before a wrap |
| dst_wcnt | output | 16 | Destination bursts remaining before a wrap |

## Verification
The assertions check the following on every cycle: idle hold, counters staying put within a burst, counter decrement at a burst end, counter reload to the working wrap size on a wrap, and addition of the word step. The position after a wrap depends on the hidden beginning address, so only the bench scenarios show it. The same goes for sign extension below zero, start taking priority over a word pulse, shadow isolation during a transfer, and the split between code 0 and code 1 address writes. A reference model in the bench follows those scenarios together with a seeded random mix of writes, starts and word pulses.

// File: rtl/dag_pkg.sv
package dag_pkg;

    localparam int DAG_ADDR_W = 32;
    localparam int DAG_STEP_W = 13;
    localparam int DAG_CNT_W  = 16;
    localparam int DAG_SIDES  = 2;
    localparam int DAG_FLD_W  = 3;

    typedef enum logic [DAG_FLD_W-1:0] {
        FLD_START = 3'd0,
        FLD_CUR   = 3'd1,
        FLD_WSTEP = 3'd2,
        FLD_BSTEP = 3'd3,
        FLD_WSIZE = 3'd4,
        FLD_WRAP  = 3'd5
    } cfg_field_e;

    typedef enum logic [1:0] {
        ADV_HOLD  = 2'd0,
        ADV_WORD  = 2'd1,
        ADV_BURST = 2'd2,
        ADV_WRAP  = 2'd3
    } adv_e;

    // Decide how one side advances in this cycle.
    function automatic adv_e adv_kind(input logic start, input logic word,
                                      input logic last, input logic hit);
        if (start || !word) return ADV_HOLD;
        if (!last)          return ADV_WORD;
        if (hit)            return ADV_WRAP;
        return ADV_BURST;
    endfunction

endpackage

// File: rtl/dag_shadow.sv
module dag_shadow
    import dag_pkg::*;
#(
    parameter int AW = DAG_ADDR_W,
    parameter int SW = DAG_STEP_W,
    parameter int CW = DAG_CNT_W
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 we,
    input  logic [DAG_FLD_W-1:0] field,
    input  logic [AW-1:0]        data,
    output logic [AW-1:0]        sh_beg,
    output logic [AW-1:0]        sh_cur,
    output logic [SW-1:0]        sh_wstep,
    output logic [SW-1:0]        sh_bstep,
    output logic [CW-1:0]        sh_wsize,
    output logic [SW-1:0]        sh_wrap
);

    always_ff @(posedge clk) begin
        if (rst) begin
            sh_beg   <= '0;
            sh_cur   <= '0;
            sh_wstep <= '0;
            sh_bstep <= '0;
            sh_wsize <= '0;
            sh_wrap  <= '0;
        end else if (we) begin
            case (cfg_field_e'(field))
                FLD_START: begin
                    sh_beg <= data;
                    sh_cur <= data;
                end
                FLD_CUR:   sh_cur   <= data;
                FLD_WSTEP: sh_wstep <= data[SW-1:0];
                FLD_BSTEP: sh_bstep <= data[SW-1:0];
                FLD_WSIZE: sh_wsize <= data[CW-1:0];
                FLD_WRAP:  sh_wrap  <= data[SW-1:0];
                default: ;
            endcase
        end
    end

endmodule

// File: rtl/dag_wrap_ctr.sv
module dag_wrap_ctr #(
    parameter int CW = 16
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          load,
    input  logic [CW-1:0] load_size,
    input  logic          burst_end,
    output logic [CW-1:0] cnt,
    output logic [CW-1:0] size_q,
    output logic          hit
);

    // Counts bursts left before a wrap; zero means this burst wraps.
    always_ff @(posedge clk) begin
        if (rst) begin
            cnt    <= '0;
            size_q <= '0;
        end else if (load) begin
            cnt    <= load_size;
            size_q <= load_size;
        end else if (burst_end) begin
            if (cnt == '0) cnt <= size_q;
            else           cnt <= cnt - 1'b1;
        end
    end

    assign hit = (cnt == '0);

endmodule

// File: rtl/dag_addr_unit.sv
module dag_addr_unit
    import dag_pkg::*;
#(
    parameter int AW = 32,
    parameter int SW = 13
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          load,
    input  logic [AW-1:0] sh_beg,
    input  logic [AW-1:0] sh_cur,
    input  logic [SW-1:0] sh_wstep,
    input  logic [SW-1:0] sh_bstep,
    input  logic [SW-1:0] sh_wrap,
    input  adv_e          adv,
    output logic [AW-1:0] cur,
    output logic [SW-1:0] wstep_q
);

    logic [AW-1:0] beg_q;
    logic [SW-1:0] bstep_q;
    logic [SW-1:0] wrap_q;
    logic [AW-1:0] beg_next;

    function automatic logic [AW-1:0] sx(input logic [SW-1:0] v);
        return {{(AW-SW){v[SW-1]}}, v};
    endfunction

    assign beg_next = beg_q + sx(wrap_q);

    always_ff @(posedge clk) begin
        if (rst) begin
            beg_q   <= '0;
            cur     <= '0;
            wstep_q <= '0;
            bstep_q <= '0;
            wrap_q  <= '0;
        end else if (load) begin
            beg_q   <= sh_beg;
            cur     <= sh_cur;
            wstep_q <= sh_wstep;
            bstep_q <= sh_bstep;
            wrap_q  <= sh_wrap;
        end else begin
            case (adv)
                ADV_WORD:  cur <= cur + sx(wstep_q);
                ADV_BURST: cur <= cur + sx(bstep_q);
                ADV_WRAP: begin
                    beg_q <= beg_next;
                    cur   <= beg_next;
                end
                default: ;
            endcase
        end
    end

endmodule

// File: rtl/dma_addr_gen.sv
module dma_addr_gen
    import dag_pkg::*;
#(
    parameter int ADDR_W = DAG_ADDR_W,
    parameter int STEP_W = DAG_STEP_W,
    parameter int CNT_W  = DAG_CNT_W
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 cfg_we,
    input  logic                 cfg_side,
    input  logic [DAG_FLD_W-1:0] cfg_field,
    input  logic [ADDR_W-1:0]    cfg_data,
    input  logic                 xfer_start,
    input  logic                 word_done,
    input  logic                 word_last,
    output logic [ADDR_W-1:0]    src_addr,
    output logic [ADDR_W-1:0]    dst_addr,
    output logic [CNT_W-1:0]     src_wcnt,
    output logic [CNT_W-1:0]     dst_wcnt
);

    localparam int NS = DAG_SIDES;

    logic [ADDR_W-1:0] cur_a   [NS];
    logic [CNT_W-1:0]  cnt_a   [NS];
    logic [CNT_W-1:0]  wsize_a [NS];
    logic [STEP_W-1:0] wstep_a [NS];

    for (genvar s = 0; s < NS; s++) begin : g_side
        logic [ADDR_W-1:0] sh_beg, sh_cur;
        logic [STEP_W-1:0] sh_wstep, sh_bstep, sh_wrap;
        logic [CNT_W-1:0]  sh_wsize;
        logic              hit;
        adv_e              adv;

        dag_shadow #(.AW(ADDR_W), .SW(STEP_W), .CW(CNT_W)) u_shadow (
            .clk      (clk),
            .rst      (rst),
            .we       (cfg_we && (cfg_side == 1'(s))),
            .field    (cfg_field),
            .data     (cfg_data),
            .sh_beg   (sh_beg),
            .sh_cur   (sh_cur),
            .sh_wstep (sh_wstep),
            .sh_bstep (sh_bstep),
            .sh_wsize (sh_wsize),
            .sh_wrap  (sh_wrap)
        );

        assign adv = adv_kind(xfer_start, word_done, word_last, hit);

        dag_wrap_ctr #(.CW(CNT_W)) u_wrap (
            .clk       (clk),
            .rst       (rst),
            .load      (xfer_start),
            .load_size (sh_wsize),
            .burst_end ((adv == ADV_BURST) || (adv == ADV_WRAP)),
            .cnt       (cnt_a[s]),
            .size_q    (wsize_a[s]),
            .hit       (hit)
        );

        dag_addr_unit #(.AW(ADDR_W), .SW(STEP_W)) u_addr (
            .clk      (clk),
            .rst      (rst),
            .load     (xfer_start),
            .sh_beg   (sh_beg),
            .sh_cur   (sh_cur),
            .sh_wstep (sh_wstep),
            .sh_bstep (sh_bstep),
            .sh_wrap  (sh_wrap),
            .adv      (adv),
            .cur      (cur_a[s]),
            .wstep_q  (wstep_a[s])
        );
    end

    assign src_addr = cur_a[0];
    assign dst_addr = cur_a[1];
    assign src_wcnt = cnt_a[0];
    assign dst_wcnt = cnt_a[1];

endmodule

// File: rtl/dag_chk.sv
module dag_chk #(
    parameter int AW = 32,
    parameter int SW = 13,
    parameter int CW = 16
) (
    input logic          clk,
    input logic          rst,
    input logic          xfer_start,
    input logic          word_done,
    input logic          word_last,
    input logic [AW-1:0] src_addr,
    input logic [AW-1:0] dst_addr,
    input logic [CW-1:0] src_wcnt,
    input logic [CW-1:0] dst_wcnt,
    input logic [CW-1:0] src_wsize,
    input logic [CW-1:0] dst_wsize,
    input logic [SW-1:0] src_wstep
);

    logic burst_end;
    assign burst_end = word_done && word_last && !xfer_start;

    p_hold_r8: assert property (@(posedge clk) disable iff (rst)
        (!word_done && !xfer_start) |=> ($stable(src_addr) && $stable(dst_addr)
                                         && $stable(src_wcnt) && $stable(dst_wcnt)));

    p_mid_burst_cnt_r4: assert property (@(posedge clk) disable iff (rst)
        (word_done && !word_last && !xfer_start) |=> ($stable(src_wcnt) && $stable(dst_wcnt)));

    p_word_step_r4: assert property (@(posedge clk) disable iff (rst)
        (word_done && !word_last && !xfer_start) |=>
            (src_addr == $past(src_addr) + {{(AW-SW){$past(src_wstep[SW-1])}}, $past(src_wstep)}));

    p_cnt_dec_r5: assert property (@(posedge clk) disable iff (rst)
        (burst_end && (src_wcnt != '0)) |=> (src_wcnt == $past(src_wcnt) - 1'b1));

    p_cnt_reload_r6: assert property (@(posedge clk) disable iff (rst)
        (burst_end && (src_wcnt == '0)) |=> (src_wcnt == $past(src_wsize)));

    p_dst_cnt_r7: assert property (@(posedge clk) disable iff (rst)
        burst_end |=> (dst_wcnt == (($past(dst_wcnt) == '0) ? $past(dst_wsize)
                                                             : $past(dst_wcnt) - 1'b1)));

endmodule

bind dma_addr_gen dag_chk #(.AW(ADDR_W), .SW(STEP_W), .CW(CNT_W)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .xfer_start (xfer_start),
    .word_done  (word_done),
    .word_last  (word_last),
    .src_addr   (src_addr),
    .dst_addr   (dst_addr),
    .src_wcnt   (src_wcnt),
    .dst_wcnt   (dst_wcnt),
    .src_wsize  (wsize_a[0]),
    .dst_wsize  (wsize_a[1]),
    .src_wstep  (wstep_a[0])
);

// File: tb/sim_dma_addr_gen.sv
module sim_dma_addr_gen;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cfg_we = 1'b0;
    logic        cfg_side = 1'b0;
    logic [2:0]  cfg_field = 3'd0;
    logic [31:0] cfg_data = '0;
    logic        xfer_start = 1'b0;
    logic        word_done = 1'b0;
    logic        word_last = 1'b0;
    logic [31:0] src_addr, dst_addr;
    logic [15:0] src_wcnt, dst_wcnt;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    dma_addr_gen u0 (
        .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_side(cfg_side),
        .cfg_field(cfg_field), .cfg_data(cfg_data), .xfer_start(xfer_start),
        .word_done(word_done), .word_last(word_last), .src_addr(src_addr),
        .dst_addr(dst_addr), .src_wcnt(src_wcnt), .dst_wcnt(dst_wcnt)
    );

    // Reference model: shadow and working state per side.
    logic [31:0] m_sbeg[2], m_scur[2], m_beg[2], m_cur[2];
    logic [12:0] m_sw[2], m_sb[2], m_sr[2], m_w[2], m_b[2], m_r[2];
    logic [15:0] m_ssz[2], m_sz[2], m_cnt[2];

    function automatic logic [31:0] sx(input logic [12:0] v);
        return {{19{v[12]}}, v};
    endfunction

    task automatic model_clear();
        for (int s = 0; s < 2; s++) begin
            m_sbeg[s] = '0; m_scur[s] = '0; m_beg[s] = '0; m_cur[s] = '0;
            m_sw[s] = '0; m_sb[s] = '0; m_sr[s] = '0;
            m_w[s] = '0; m_b[s] = '0; m_r[s] = '0;
            m_ssz[s] = '0; m_sz[s] = '0; m_cnt[s] = '0;
        end
    endtask

    task automatic model_step(input bit xs, input bit we, input bit sd,
                              input logic [2:0] fl, input logic [31:0] dt,
                              input bit wd, input bit lst);
        for (int s = 0; s < 2; s++) begin
            if (xs) begin
                m_beg[s] = m_sbeg[s]; m_cur[s] = m_scur[s];
                m_w[s] = m_sw[s]; m_b[s] = m_sb[s]; m_r[s] = m_sr[s];
                m_sz[s] = m_ssz[s]; m_cnt[s] = m_ssz[s];
            end else if (wd) begin
                if (!lst) m_cur[s] = m_cur[s] + sx(m_w[s]);
                else if (m_cnt[s] == 16'd0) begin
                    m_beg[s] = m_beg[s] + sx(m_r[s]);
                    m_cur[s] = m_beg[s];
                    m_cnt[s] = m_sz[s];
                end else begin
                    m_cur[s] = m_cur[s] + sx(m_b[s]);
                    m_cnt[s] = m_cnt[s] - 16'd1;
                end
            end
        end
        if (we) begin
            case (fl)
                3'd0: begin m_sbeg[sd] = dt; m_scur[sd] = dt; end
                3'd1: m_scur[sd] = dt;
                3'd2: m_sw[sd] = dt[12:0];
                3'd3: m_sb[sd] = dt[12:0];
                3'd4: m_ssz[sd] = dt[15:0];
                3'd5: m_sr[sd] = dt[12:0];
                default: ;
            endcase
        end
    endtask

    task automatic chk(input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    task automatic chk_all(input string tag);
        chk(tag, "src_addr", src_addr, m_cur[0]);
        chk(tag, "dst_addr", dst_addr, m_cur[1]);
        chk(tag, "src_wcnt", {16'd0, src_wcnt}, {16'd0, m_cnt[0]});
        chk(tag, "dst_wcnt", {16'd0, dst_wcnt}, {16'd0, m_cnt[1]});
    endtask

    // One clock: drive at negedge, sample at the following negedge.
    task automatic cyc(input string tag, input bit xs, input bit we, input bit sd,
                       input logic [2:0] fl, input logic [31:0] dt,
                       input bit wd, input bit lst);
        xfer_start = xs; cfg_we = we; cfg_side = sd; cfg_field = fl;
        cfg_data = dt; word_done = wd; word_last = lst;
        @(negedge clk);
        model_step(xs, we, sd, fl, dt, wd, lst);
        chk_all(tag);
        xfer_start = 1'b0; cfg_we = 1'b0; word_done = 1'b0; word_last = 1'b0;
    endtask

    task automatic wr(input bit sd, input logic [2:0] fl, input logic [31:0] dt);
        cyc("R2", 1'b0, 1'b1, sd, fl, dt, 1'b0, 1'b0);
    endtask

    task automatic go(input string tag);
        cyc(tag, 1'b1, 1'b0, 1'b0, 3'd0, '0, 1'b0, 1'b0);
    endtask

    task automatic word(input string tag, input bit lst);
        cyc(tag, 1'b0, 1'b0, 1'b0, 3'd0, '0, 1'b1, lst);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL R1 watchdog actual=timeout expected=finish");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        model_clear();
        repeat (3) @(negedge clk);
        chk_all("R1");
        rst = 1'b0;
        @(negedge clk);
        chk_all("R1");

        // Source: start 0x1000, word +1, burst +4, wrap every 2 bursts, wrap +0x100
        wr(0, 3'd0, 32'h1000); wr(0, 3'd2, 32'd1); wr(0, 3'd3, 32'd4);
        wr(0, 3'd4, 32'd1);    wr(0, 3'd5, 32'h100);
        // Destination: start 0x10, word -1, burst -16, wrap every burst, wrap -2
        wr(1, 3'd0, 32'h10);   wr(1, 3'd2, 32'h1FFF); wr(1, 3'd3, 32'h1FF0);
        wr(1, 3'd4, 32'd0);    wr(1, 3'd5, 32'h1FFE);
        chk("R2", "src before start", src_addr, 32'h0);

        go("R3");
        chk("R3", "src start", src_addr, 32'h1000);
        chk("R3", "src cnt", {16'd0, src_wcnt}, 32'd1);
        word("R4", 1'b0);
        chk("R4", "src word", src_addr, 32'h1001);
        chk("R10", "dst word neg", dst_addr, 32'hF);
        word("R5", 1'b1);
        chk("R5", "src burst", src_addr, 32'h1005);
        chk("R7", "dst wraps alone", dst_addr, 32'hE);
        word("R6", 1'b1);
        chk("R6", "src wrap", src_addr, 32'h1100);
        chk("R6", "src cnt reload", {16'd0, src_wcnt}, 32'd1);
        chk("R7", "dst wrap again", dst_addr, 32'hC);
        repeat (3) cyc("R8", 1'b0, 1'b0, 1'b0, 3'd0, '0, 1'b0, 1'b0);

        // Below zero
        wr(1, 3'd0, 32'h1);
        go("R3");
        word("R10", 1'b0);
        word("R10", 1'b0);
        chk("R10", "dst below zero", dst_addr, 32'hFFFF_FFFF);

        // Start and word together
        cyc("R9", 1'b1, 1'b0, 1'b0, 3'd0, '0, 1'b1, 1'b0);
        chk("R9", "src start wins", src_addr, 32'h1000);
        chk("R9", "dst start wins", dst_addr, 32'h1);

        // Writes during transfer, including unused field codes
        wr(0, 3'd0, 32'h2000);
        wr(0, 3'd7, 32'hFFFF_FFFF);
        wr(0, 3'd6, 32'hFFFF_FFFF);
        chk("R2", "src untouched", src_addr, 32'h1000);
        go("R3");
        chk("R2", "src new start", src_addr, 32'h2000);
        word("R2", 1'b0);
        chk("R2", "word step kept", src_addr, 32'h2001);

        // Current-only write vs beginning
        wr(0, 3'd0, 32'h3000);
        wr(0, 3'd1, 32'h3050);
        wr(0, 3'd4, 32'd0);
        go("R11");
        chk("R11", "src cur only", src_addr, 32'h3050);
        word("R11", 1'b1);
        chk("R11", "wrap from beginning", src_addr, 32'h3100);

        // Seeded random mix
        void'($urandom(32'd24680));
        for (int i = 0; i < 4000; i++) begin
            int unsigned r;
            bit xs, we, sd, wd, lst;
            logic [2:0] fl;
            logic [31:0] dt;
            string tag;
            r   = $urandom % 100;
            xs  = (r < 4);
            wd  = (r >= 20);
            lst = ($urandom % 4) == 0;
            we  = ($urandom % 6) == 0;
            sd  = 1'($urandom);
            fl  = 3'($urandom);
            dt  = (fl == 3'd4) ? ($urandom % 4) : $urandom;
            if (xs)                      tag = wd ? "R9" : "R3";
            else if (!wd)                tag = "R8";
            else if (!lst)               tag = "R4";
            else if (m_cnt[0] == 16'd0)  tag = "R6";
            else                         tag = "R5";
            cyc(tag, xs, we, sd, fl, dt, wd, lst);
        end

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule